// File: doc/BRIEF.md
# Iterative Decoder Early-Termination Sequencer

This block sequences the passes of an iterative parity-check decoder. A start request opens a block decode. The sequencer then asks the node arithmetic for one iteration pass at a time. While a pass runs it collects the parity-satisfied flags that the check nodes report. Each flag is the sign product of one check: it is 1 when that product is positive. The node arithmetic and the message memories sit outside this block.

A decode ends at the first pass in which every reported check was satisfied. That is the point where the hard decisions form a valid codeword. If the programmed iteration limit is reached first, the block is marked as failed. In either case the sequencer raises a completion pulse and holds a success flag together with the number of passes used. Decode time therefore varies from block to block. The pass count can feed later stages, for example to estimate channel quality.

Top module: `decode_iter_ctrl`

## Requirements
- R1: After reset, busy, done, success and iterGo are 0 and iterCount is 0.
- R2: startReq while idle raises busy and iterGo in the next cycle and clears iterCount to 0. iterGo is a one-cycle pulse at the start of each pass.
- R3: A pass counts as satisfied only if every lane of chkOk is 1 on every cycle with chkValid high during that pass. This includes a chkValid beat in the same cycle as passDone. The accumulation restarts at each pass, so a failed earlier pass does not affect a later one.
- R4: After a satisfied pass, done pulses in the cycle following passDone, with success=1. No further iterGo is issued.
- R5: After an unsatisfied pass with fewer than the limit completed, iterGo rises in the cycle following passDone.
- R6: When the limit is reached without a satisfied pass, done pulses with success=0 and iterCount equal to the limit.
- R7: maxIter is sampled at startReq. A value of 0 acts as 1, and later changes to maxIter do not affect the running decode.
- R8: iterCount counts the completed passes. It and success hold their values after done until the next accepted start.
- R9: done lasts one cycle. busy is high from the cycle after start through the done cycle, then falls.
- R10: startReq while busy is ignored. The decode continues and the count is not cleared.
- R11: passDone and chkValid while idle have no effect on iterCount, success or done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to begin decoding a block |
| maxIter | input | ITER_W | Iteration limit, sampled at start (0 acts as 1) |
| chkValid | input | 1 | chkOk carries check flags this cycle |
| chkOk | input | LANES | Per-check satisfied flags (1 = sign product positive) |
| passDone | input | 1 | Current pass has finished |
| iterGo | output | 1 | Pulse: begin a new iteration pass |
| busy | output | 1 | Decode in progress |
| done | output | 1 | One-cycle completion pulse |
| success | output | 1 | Last decode ended on a valid codeword |
| iterCount | output | ITER_W | Passes completed in the current or last decode |

## Verification
Two situations are hard to reach from the ports. The first is a pass whose only failing flag arrives in the same cycle as passDone. The second is a start request landing in the middle of a running decode. The bench sweeps every limit from 0 to 5 against every first-satisfied pass from 1 to 6. In each failing pass it moves the single zero flag across beats and lanes, so some runs put it on the passDone beat. In alternate runs it pulses startReq during the first pass, and it changes maxIter once the decode is under way. The bench then checks the final count and success flag against values it computes from the limit and the schedule.

// File: rtl/iter_ctrl_pkg.sv
package iter_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } iterState_t;

  typedef struct packed {
    logic clrAll;  // accept a new block
    logic clrAcc;  // open a pass
    logic step;    // close a pass
  } ctrlStrobe_t;

endpackage

// File: rtl/iter_datapath.sv
module iter_datapath
  import iter_ctrl_pkg::*;
#(
  parameter int ITER_W = 4,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [ITER_W-1:0] maxIter,
  input  logic              chkValid,
  input  logic [LANES-1:0]  chkOk,
  output logic              passOk,
  output logic              lastIter,
  output logic [ITER_W-1:0] iterCount,
  output logic              success,
  output logic [ITER_W-1:0] effMax
);

  localparam logic [ITER_W-1:0] ONE = ITER_W'(1);

  logic             accOk;
  logic [LANES-1:0] laneAnd;
  logic             beatOk;

  // lane-by-lane AND chain over the flags of one beat
  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      if (g == 0) begin : g_first
        assign laneAnd[g] = chkOk[g];
      end else begin : g_rest
        assign laneAnd[g] = laneAnd[g-1] & chkOk[g];
      end
    end
  endgenerate

  assign beatOk   = chkValid ? laneAnd[LANES-1] : 1'b1;
  assign passOk   = accOk & beatOk;
  assign lastIter = ({1'b0, iterCount} + {1'b0, ONE}) >= {1'b0, effMax};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accOk <= 1'b1;
    end else if (strb.clrAcc) begin
      accOk <= 1'b1;
    end else if (chkValid) begin
      accOk <= accOk & laneAnd[LANES-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      iterCount <= '0;
      success   <= 1'b0;
      effMax    <= ONE;
    end else if (strb.clrAll) begin
      iterCount <= '0;
      success   <= 1'b0;
      effMax    <= (maxIter == '0) ? ONE : maxIter;
    end else if (strb.step) begin
      iterCount <= iterCount + ONE;
      success   <= passOk;
    end
  end

  a_r7_limit_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    effMax != '0);
  a_r8_count_holds: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.clrAll || strb.step) |=> $stable(iterCount) && $stable(success));
  a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    iterCount <= effMax);

endmodule

// File: rtl/iter_control.sv
module iter_control
  import iter_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        passDone,
  input  logic        passOk,
  input  logic        lastIter,
  output ctrlStrobe_t strb,
  output logic        iterGo,
  output logic        busy,
  output logic        done
);

  iterState_t state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: if (startReq) nextState = ST_RUN;
      ST_RUN:  nextState = ST_WAIT;
      ST_WAIT: if (passDone) nextState = (passOk || lastIter) ? ST_DONE : ST_RUN;
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strb.clrAll = (state == ST_IDLE) && startReq;
    strb.clrAcc = (state == ST_RUN);
    strb.step   = (state == ST_WAIT) && passDone;
  end

  assign iterGo = (state == ST_RUN);
  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_DONE);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);
  a_r2_go_pulse: assert property (@(posedge clk) disable iff (!rstN)
    iterGo |=> !iterGo);
  a_r4_stop_on_ok: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && passDone && passOk) |=> done && !iterGo);
  a_r10_busy_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && startReq) |=> busy);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startReq) |=> !busy && !done);

endmodule

// File: rtl/decode_iter_ctrl.sv
module decode_iter_ctrl
  import iter_ctrl_pkg::*;
#(
  parameter int ITER_W = 4,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ITER_W-1:0] maxIter,
  input  logic              chkValid,
  input  logic [LANES-1:0]  chkOk,
  input  logic              passDone,
  output logic              iterGo,
  output logic              busy,
  output logic              done,
  output logic              success,
  output logic [ITER_W-1:0] iterCount
);

  ctrlStrobe_t       strb;
  logic              passOk;
  logic              lastIter;
  logic [ITER_W-1:0] effMax;

  iter_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .passDone (passDone),
    .passOk   (passOk),
    .lastIter (lastIter),
    .strb     (strb),
    .iterGo   (iterGo),
    .busy     (busy),
    .done     (done)
  );

  iter_datapath #(.ITER_W(ITER_W), .LANES(LANES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .maxIter   (maxIter),
    .chkValid  (chkValid),
    .chkOk     (chkOk),
    .passOk    (passOk),
    .lastIter  (lastIter),
    .iterCount (iterCount),
    .success   (success),
    .effMax    (effMax)
  );

  a_r6_fail_at_limit: assert property (@(posedge clk) disable iff (!rstN)
    (done && !success) |-> iterCount == effMax);

endmodule

// File: tb/sim_decode_iter_ctrl.sv
module sim_decode_iter_ctrl;

  localparam int ITER_W = 4;
  localparam int LANES  = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startReq = 1'b0;
  logic [ITER_W-1:0] maxIter = '0;
  logic              chkValid = 1'b0;
  logic [LANES-1:0]  chkOk = '0;
  logic              passDone = 1'b0;
  logic              iterGo, busy, done, success;
  logic [ITER_W-1:0] iterCount;

  int nTests = 0;
  int nFails = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  decode_iter_ctrl #(.ITER_W(ITER_W), .LANES(LANES)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .maxIter(maxIter),
    .chkValid(chkValid), .chkOk(chkOk), .passDone(passDone),
    .iterGo(iterGo), .busy(busy), .done(done), .success(success),
    .iterCount(iterCount)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      nFails = nFails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected < 100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nTests = nTests + 1;
    if (act != exp) begin
      nFails = nFails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One decode: limit mx, first satisfied pass firstOk, optional busy start.
  task automatic runDecode(input int mx, input int firstOk, input bit busyStart);
    int effM, nExp;
    bit okExp;
    bit aborted;
    effM  = (mx == 0) ? 1 : mx;
    okExp = (firstOk <= effM);
    nExp  = okExp ? firstOk : effM;
    aborted = 0;
    maxIter  = ITER_W'(mx);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    maxIter  = '1;  // R7: change after start must not matter
    chk("R2 busy after start", busy, 1);
    chk("R2 count cleared", iterCount, 0);
    for (int p = 1; p <= nExp && !aborted; p++) begin
      chk("R2/R5 iterGo at pass start", iterGo, 1);
      if (!iterGo) begin
        aborted = 1;
      end else begin
        @(negedge clk);  // now waiting on the pass
        for (int b = 0; b < 3; b++) begin
          chkValid = 1'b1;
          chkOk    = '1;
          if (p != firstOk && b == (p % 3)) chkOk[p % 2] = 1'b0;
          passDone = (b == 2);
          startReq = busyStart && (p == 1) && (b == 0);
          @(negedge clk);
        end
        chkValid = 1'b0; chkOk = '0; passDone = 1'b0; startReq = 1'b0;
        if (p < nExp) chk("R3/R5 still running", done, 0);
      end
    end
    if (!aborted) begin
      chk("R4/R6 done pulse", done, 1);
      chk("R4/R6 no extra iterGo", iterGo, 0);
      chk("R4/R6 success flag", success, int'(okExp));
      chk("R6/R10 pass count", iterCount, nExp);
      @(negedge clk);
      chk("R9 done one cycle", done, 0);
      chk("R9 busy falls", busy, 0);
      chk("R8 count held", iterCount, nExp);
      chk("R8 success held", success, int'(okExp));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy reset", busy, 0);
    chk("R1 done reset", done, 0);
    chk("R1 success reset", success, 0);
    chk("R1 count reset", iterCount, 0);
    chk("R1 iterGo reset", iterGo, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int mx = 0; mx <= 5; mx++) begin
      for (int f = 1; f <= 6; f++) begin
        runDecode(mx, f, ((mx + f) % 2) == 1);
        @(negedge clk);
      end
    end

    // R11: stray pass activity while idle
    runDecode(4, 2, 1'b0);
    chkValid = 1'b1; chkOk = '0; passDone = 1'b1;
    @(negedge clk);
    chkValid = 1'b0; passDone = 1'b0;
    @(negedge clk);
    chk("R11 idle count unchanged", iterCount, 2);
    chk("R11 idle success unchanged", success, 1);
    chk("R11 idle no done", done, 0);
    chk("R11 idle not busy", busy, 0);

    // R7: limit above sweep range, fails at limit
    runDecode(7, 9, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule